// File: doc/BRIEF.md
# Hot-Swap Bus Join Sequencer

This block decides when a card-side two-wire bus (clock and data) may be joined to the live backplane bus after a card is inserted or switched on. It watches a synchronous enable input and the logic levels of all four lines, and drives the control signals around an external pass path. These are a join strobe that closes the path, a precharge enable for the line bias circuit, an enable for the rise-time accelerators, and an active-high ready status.

When enable rises, a settling period of programmable length runs with precharge on. Only after this period is the detector armed. The join then happens on one of two events. The first is a STOP condition on the backplane pair while all four lines are high. The second is all four lines staying high for a programmable idle count. Dropping enable returns the block to isolation at the next clock edge. The analog parts (bias levels, thresholds, the buffers themselves) sit outside and see only the control outputs.

Top module: `hsbus_join_seq`

## Requirements
- R1: While reset is asserted (active-low, synchronous), join_o, ready_o and accel_en_o are 0 and precharge_o is 0.
- R2: While en_i is low, all four outputs stay 0 whatever the line inputs do.
- R3: At the first clock edge that samples en_i high in the isolated state, precharge_o goes to 1. The settling phase then holds for INIT_CYCLES cycles, and no join occurs in it.
- R4: A STOP condition that occurs during the settling phase does not cause a join.
- R5: Once armed, the block joins after IDLE_CYCLES consecutive clock edges at which all four synchronized lines are high. With lines already idle, join_o rises 1+INIT_CYCLES+IDLE_CYCLES cycles after en_i is first sampled high.
- R6: A low sample on any of the four lines during the armed phase restarts the idle count from zero.
- R7: Once armed, a backplane data rise while backplane clock is high and all four lines are high joins the buses. join_o rises on the third clock edge after the data line changes (two synchronizer stages, then the decision).
- R8: A backplane data rise while backplane clock is low, or while any card-side line is low, is not a STOP condition and causes no early join.
- R9: At the join, join_o, ready_o and accel_en_o go to 1 and precharge_o goes to 0 on the same clock edge. precharge_o stays 1 from the start of settling until that edge.
- R10: en_i sampled low at a clock edge forces all outputs to 0 at that edge, from any phase. A later enable restarts the full settling period.
- R11: Once joined, the block stays joined while en_i stays high, regardless of line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable, synchronous to clk |
| bp_scl_i | input | 1 | Sampled level of the backplane clock line |
| bp_sda_i | input | 1 | Sampled level of the backplane data line |
| cd_scl_i | input | 1 | Sampled level of the card clock line |
| cd_sda_i | input | 1 | Sampled level of the card data line |
| join_o | output | 1 | Closes the pass path between the two sides |
| precharge_o | output | 1 | Enables line precharge bias |
| accel_en_o | output | 1 | Enables rise-time accelerators |
| ready_o | output | 1 | High when the two sides are joined |

## Verification
The bench builds the block with INIT_CYCLES=6 and IDLE_CYCLES=10. With these values, a join through the idle path (12 cycles after the last low line is released) and a join through STOP (3 cycles after the data rise) land on clearly different cycles. A STOP placed inside the settling window is then visible as a join that arrives too early or not at all. The short idle count also lets a single-cycle low pulse partway through the count shift the join by an exact, checkable number of cycles.

// File: rtl/hsbus_join_pkg.sv
// Shared definitions for the hot-swap join sequencer.
// Assumes line vectors are ordered with the indices below.
package hsbus_join_pkg;

    localparam int HJ_LINES  = 4;
    localparam int HJ_BP_SCL = 0;
    localparam int HJ_BP_SDA = 1;
    localparam int HJ_CD_SCL = 2;
    localparam int HJ_CD_SDA = 3;

    typedef enum logic [1:0] {
        HJ_OFF   = 2'd0,
        HJ_INIT  = 2'd1,
        HJ_ARMED = 2'd2,
        HJ_ON    = 2'd3
    } hj_state_t;

endpackage

// File: rtl/hsbus_line_sync.sv
// Multi-stage synchronizer for a vector of slow line levels.
// Assumes lines idle high, so every stage resets to 1 to avoid a false
// edge after reset.
module hsbus_line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the line levels one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '1;
                else if (s == 0) stg_q[s] <= in_i;
                else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign out_o = stg_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] warm_q;
            // Count edges since reset so the delay check only looks back over valid cycles
            always_ff @(posedge clk) begin
                if (!rst_n) warm_q <= 2'd0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            // R7
            sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (out_o == $past(in_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/hsbus_cycle_timer.sv
// Counts enabled cycles and flags the cycle that completes LIMIT of them.
// Assumes clr_i has priority; the count wraps to zero on completion.
module hsbus_cycle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && !clr_i && (cnt_q == LAST);

    // Advance the count while running, restart it on clear or completion
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (done_o) cnt_q <= '0;
        else if (run_i)  cnt_q <= cnt_q + 1'b1;
    end

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/hsbus_stop_watch.sv
// Flags a STOP condition: data rising while clock is high.
// Assumes synchronized inputs; the history flop resets high so no
// STOP is reported on the first cycle after reset.
module hsbus_stop_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic stop_o
);

    logic sda_q;

    // Remember the previous data level
    always_ff @(posedge clk) begin
        if (!rst_n) sda_q <= 1'b1;
        else        sda_q <= sda_i;
    end

    assign stop_o = scl_i && sda_i && !sda_q;

    // R8
    stop_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !$past(sda_i));

endmodule

// File: rtl/hsbus_join_seq.sv
// Hot-swap join sequencer: isolates, settles, arms, then joins a card bus
// to a backplane bus on an idle timeout or a STOP with all lines high.
// Assumes en_i is synchronous to clk; line inputs may be asynchronous.
module hsbus_join_seq
    import hsbus_join_pkg::*;
#(
    parameter int INIT_CYCLES = 64,
    parameter int IDLE_CYCLES = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bp_scl_i,
    input  logic bp_sda_i,
    input  logic cd_scl_i,
    input  logic cd_sda_i,
    output logic join_o,
    output logic precharge_o,
    output logic accel_en_o,
    output logic ready_o
);

    logic [HJ_LINES-1:0] raw_l;
    logic [HJ_LINES-1:0] ln_s;
    logic                all_high;
    logic                stop_p;
    logic                init_run, init_done;
    logic                idle_run, idle_done;
    hj_state_t           state_q, state_d;

    assign raw_l[HJ_BP_SCL] = bp_scl_i;
    assign raw_l[HJ_BP_SDA] = bp_sda_i;
    assign raw_l[HJ_CD_SCL] = cd_scl_i;
    assign raw_l[HJ_CD_SDA] = cd_sda_i;

    hsbus_line_sync #(.WIDTH(HJ_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (raw_l),
        .out_o (ln_s)
    );

    assign all_high = &ln_s;

    hsbus_stop_watch u_stop (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (ln_s[HJ_BP_SCL]),
        .sda_i  (ln_s[HJ_BP_SDA]),
        .stop_o (stop_p)
    );

    assign init_run = (state_q == HJ_INIT);
    assign idle_run = (state_q == HJ_ARMED) && all_high;

    hsbus_cycle_timer #(.LIMIT(INIT_CYCLES)) u_init_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!init_run),
        .run_i  (init_run),
        .done_o (init_done)
    );

    hsbus_cycle_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!idle_run),
        .run_i  (idle_run),
        .done_o (idle_done)
    );

    // Choose the next phase; a low enable wins over everything
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = HJ_OFF;
        end else begin
            unique case (state_q)
                HJ_OFF:   state_d = HJ_INIT;
                HJ_INIT:  if (init_done) state_d = HJ_ARMED;
                HJ_ARMED: if (idle_done || (stop_p && all_high)) state_d = HJ_ON;
                HJ_ON:    state_d = HJ_ON;
                default:  state_d = HJ_OFF;
            endcase
        end
    end

    // Hold the phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HJ_OFF;
        else        state_q <= state_d;
    end

    // Register each control output from the next phase so every pin is a flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            join_o      <= 1'b0;
            ready_o     <= 1'b0;
            accel_en_o  <= 1'b0;
            precharge_o <= 1'b0;
        end else begin
            join_o      <= (state_d == HJ_ON);
            ready_o     <= (state_d == HJ_ON);
            accel_en_o  <= (state_d == HJ_ON);
            precharge_o <= (state_d == HJ_INIT) || (state_d == HJ_ARMED);
        end
    end

    // R10
    drop_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!join_o && !ready_o && !accel_en_o && !precharge_o));
    // R9
    join_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_o |-> (ready_o && accel_en_o && !precharge_o));
    // R3
    enable_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HJ_OFF && en_i) |=> (precharge_o && !join_o));
    // R5
    join_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(join_o) |-> $past(all_high));
    // R11
    hold_connected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (join_o && en_i) |=> join_o);
    // R4
    armed_before_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(join_o) |-> ($past(state_q) == HJ_ARMED));

endmodule

// File: tb/hsbus_join_seq_test.sv
module hsbus_join_seq_test;

    localparam int INIT = 6;
    localparam int IDLE = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic bscl = 1'b1, bsda = 1'b1, cscl = 1'b1, csda = 1'b1;
    logic join_w, pre_w, acc_w, rdy_w;

    always #2 clk = ~clk;

    hsbus_join_seq #(.INIT_CYCLES(INIT), .IDLE_CYCLES(IDLE)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .bp_scl_i    (bscl),
        .bp_sda_i    (bsda),
        .cd_scl_i    (cscl),
        .cd_sda_i    (csda),
        .join_o      (join_w),
        .precharge_o (pre_w),
        .accel_en_o  (acc_w),
        .ready_o     (rdy_w)
    );

    typedef struct {
        int    at;
        bit    j;
        bit    p;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: after each edge, compare every expectation due in this cycle
    always begin
        @(posedge clk);
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                n_cmp++;
                if (join_w !== q[i].j || rdy_w !== q[i].j || acc_w !== q[i].j || pre_w !== q[i].p) begin
                    n_bad++;
                    $display("FAIL %s cyc=%0d actual join=%b ready=%b accel=%b pre=%b expected join/ready/accel=%b pre=%b",
                             q[i].tag, cyc, join_w, rdy_w, acc_w, pre_w, q[i].j, q[i].p);
                end
                q.delete(i);
            end
        end
    end

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic expect_span(int d0, int d1, bit j, bit p, string tag);
        for (int d = d0; d <= d1; d++) q.push_back('{cyc + d, j, p, tag});
    endtask

    task automatic lines(logic a, logic b, logic c, logic d);
        bscl = a; bsda = b; cscl = c; csda = d;
    endtask

    task automatic finish_run();
        if (q.size() != 0) begin
            n_bad += q.size();
            n_cmp += q.size();
            $display("FAIL pending expectations left: actual %0d expected 0", q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired: actual running expected done");
            finish_run();
        end
    end

    // Driver
    initial begin
        @(negedge clk);
        // R1: outputs low during reset
        expect_span(1, 4, 1'b0, 1'b0, "R1 reset state");
        step(5);
        rst_n = 1'b1;

        // R2: enable low, lines busy
        expect_span(1, 20, 1'b0, 1'b0, "R2 disabled ignores lines");
        for (int k = 0; k < 10; k++) begin
            lines(k[0], k[1], ~k[0], 1'b1);
            step(2);
        end
        lines(1, 1, 1, 1);
        step(4);

        // R3, R5, R9: idle lines, join after settling plus idle count
        en = 1'b1;
        expect_span(1, INIT + IDLE, 1'b0, 1'b1, "R3 settling/armed precharge");
        expect_span(INIT + IDLE + 1, INIT + IDLE + 2, 1'b1, 1'b0, "R5 R9 idle join");
        step(INIT + IDLE + 3);

        // R11: joined stays joined through line activity
        expect_span(1, 12, 1'b1, 1'b0, "R11 hold joined");
        for (int k = 0; k < 6; k++) begin
            lines(k[0], ~k[0], k[1], 1'b0);
            step(2);
        end
        lines(1, 1, 1, 1);

        // R10: drop enable from joined
        en = 1'b0;
        expect_span(1, 2, 1'b0, 1'b0, "R10 drop from joined");
        step(4);

        // R4: STOP inside settling must not join early
        lines(1, 0, 1, 1);
        en = 1'b1;
        expect_span(1, INIT + IDLE, 1'b0, 1'b1, "R4 stop during settling ignored");
        expect_span(INIT + IDLE + 1, INIT + IDLE + 1, 1'b1, 1'b0, "R4 late idle join");
        step(3);
        lines(1, 1, 1, 1);
        step(INIT + IDLE);
        en = 1'b0;
        step(4);

        // R7: STOP once armed joins on the third edge
        lines(1, 0, 1, 1);
        en = 1'b1;
        expect_span(1, INIT + 4, 1'b0, 1'b1, "R7 waiting for stop");
        step(INIT + 4);
        lines(1, 1, 1, 1);
        expect_span(1, 2, 1'b0, 1'b1, "R7 stop latency");
        expect_span(3, 4, 1'b1, 1'b0, "R7 R9 stop join");
        step(5);
        en = 1'b0;
        step(4);

        // R8: data rise with clock low is not a STOP
        lines(0, 0, 1, 1);
        en = 1'b1;
        expect_span(1, INIT + 4, 1'b0, 1'b1, "R8 armed, clock low");
        step(INIT + 4);
        lines(0, 1, 1, 1);
        expect_span(1, 3, 1'b0, 1'b1, "R8 no stop with clock low");
        step(3);
        lines(1, 1, 1, 1);
        expect_span(1, IDLE + 1, 1'b0, 1'b1, "R8 idle path only");
        expect_span(IDLE + 2, IDLE + 2, 1'b1, 1'b0, "R8 idle join");
        step(IDLE + 3);
        en = 1'b0;
        step(4);

        // R8 with card data low, then R6 restart by a one-cycle low pulse
        lines(1, 0, 1, 0);
        en = 1'b1;
        expect_span(1, INIT + 4, 1'b0, 1'b1, "R8 armed, card low");
        step(INIT + 4);
        lines(1, 1, 1, 0);
        expect_span(1, 4, 1'b0, 1'b1, "R8 no stop with card line low");
        step(4);
        lines(1, 1, 1, 1);
        expect_span(1, 5, 1'b0, 1'b1, "R6 counting");
        step(5);
        lines(1, 1, 0, 1);
        expect_span(1, IDLE + 2, 1'b0, 1'b1, "R6 count restarted");
        expect_span(IDLE + 3, IDLE + 3, 1'b1, 1'b0, "R6 join after restart");
        step(1);
        lines(1, 1, 1, 1);
        step(IDLE + 4);
        en = 1'b0;
        step(4);

        // R10: drop during settling, then full restart
        en = 1'b1;
        expect_span(1, 3, 1'b0, 1'b1, "R10 settling before drop");
        step(3);
        en = 1'b0;
        expect_span(1, 1, 1'b0, 1'b0, "R10 drop during settling");
        step(1);
        en = 1'b1;
        expect_span(1, INIT + IDLE, 1'b0, 1'b1, "R10 full settling again");
        expect_span(INIT + IDLE + 1, INIT + IDLE + 1, 1'b1, 1'b0, "R10 join after restart");
        step(INIT + IDLE + 3);
        en = 1'b0;
        step(4);

        finished = 1'b1;
        finish_run();
    end

endmodule